// File: doc/BRIEF.md
# Re-Sequencing Stage with Reconfiguration Gap Filler

This block sits between the stage that pulls net data out of an incoming protocol and the stage that packs words into an outgoing protocol. In working mode it passes parallel words straight through or assembles a bit-serial input into words. Each finished word appears on a registered output with a one-cycle valid pulse. The output register always holds the last word sent, and that value is the block's only state shared between its modes.

While the upstream producer is being swapped out, a controlling unit raises a mode input. The block then ignores its input completely. On every pulse of a sample strobe it makes an output word by itself, so a downstream consumer such as an actuator keeps getting samples at its normal rate. A select input picks where each generated word comes from:
- repeat the last word;
- add one to the last word, stopping at all-ones;
- step through a short constant table.

Top module: `gapfill_seq`

## Requirements
- R1: After reset `outValid` is 0 and `outWord` is 0.
- R2: In working mode (`reconfigMode`=0) with `serialMode`=0, a cycle with `inValid`=1 puts `inWord` on `outWord` at the next clock edge, and `outValid` is 1 for exactly that one cycle.
- R3: In working mode with `serialMode`=1, each `inValid` cycle shifts in `inBit`, most significant bit first. After the WORD_W-th bit, the assembled word appears on `outWord` with a one-cycle `outValid`. No `outValid` appears before that bit.
- R4: In working mode, `sampleStrobe` has no effect, and `outValid` is raised only by input data.
- R5: In fallback mode (`reconfigMode`=1), `inValid`, `inBit` and `inWord` are discarded. Without a `sampleStrobe`, `outValid` stays 0 and `outWord` is unchanged.
- R6: In fallback mode, a `sampleStrobe` with `fillSel` 0 or 3 re-emits the last word with `outValid`=1.
- R7: In fallback mode, a `sampleStrobe` with `fillSel`=1 emits the last word plus one. The result saturates at all-ones instead of wrapping.
- R8: In fallback mode, a `sampleStrobe` with `fillSel`=2 emits table entries in order. Entry i is `SEQ_TABLE[i*WORD_W +: WORD_W]`. The sequence starts at entry 0 each time fallback mode is entered and wraps to entry 0 after entry SEQ_LEN-1. The defaults are 0x10, 0x20, 0x30, 0x40 with SEQ_LEN=4.
- R9: Serial bits received before fallback mode are dropped. After the return to working mode, assembly restarts at the first bit.
- R10: The fallback modes continue from the last word emitted in any mode. Normal word transfer resumes as soon as working mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reconfigMode | input | 1 | 1 selects fallback mode, 0 selects working mode |
| serialMode | input | 1 | Working mode: 1 = bit-serial assembly, 0 = parallel words |
| fillSel | input | 2 | Fallback source: 0/3 hold, 1 increment, 2 table |
| inValid | input | 1 | Input bit or word is present |
| inBit | input | 1 | Serial input bit |
| inWord | input | WORD_W | Parallel input word |
| sampleStrobe | input | 1 | Output sample tick used in fallback mode |
| outWord | output | WORD_W | Last emitted word |
| outValid | output | 1 | One-cycle pulse for each emitted word |

## Verification
A serial bit counter left out of step would move the valid pulse of the next assembled word. It would also rotate the word's bits, which shows on the first word after a return from fallback mode. A table index that fails to restart or to wrap shows as a wrong value on the first or the (SEQ_LEN+1)-th strobe. A missing saturation shows as all-zeros one strobe after all-ones. A leak of input data during fallback shows as an unrequested `outValid` in the same cycle as the input.

// File: rtl/gfs_pkg.sv
package gfs_pkg;

  typedef enum logic [1:0] {
    FILL_HOLD  = 2'd0,
    FILL_INC   = 2'd1,
    FILL_SEQ   = 2'd2,
    FILL_HOLDB = 2'd3
  } fillSrc_e;

  typedef struct packed {
    logic shiftEn;
    logic loadSerial;
    logic loadWord;
    logic emitHold;
    logic emitInc;
    logic emitSeq;
  } ctrlStrb_t;

  localparam int MAX_SEQ = 8;
  localparam int IDX_W   = 3;

endpackage

// File: rtl/gfs_ctrl.sv
module gfs_ctrl
  import gfs_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int SEQ_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reconfigMode,
  input  logic             serialMode,
  input  logic [1:0]       fillSel,
  input  logic             inValid,
  input  logic             sampleStrobe,
  output ctrlStrb_t        strb,
  output logic [IDX_W-1:0] seqIdx
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             working;
  logic             fillTick;
  fillSrc_e         src;

  assign working  = !reconfigMode;
  assign fillTick = reconfigMode && sampleStrobe;
  assign src      = fillSrc_e'(fillSel);

  always_comb begin
    strb            = '0;
    strb.shiftEn    = working && serialMode && inValid;
    strb.loadSerial = strb.shiftEn && (bitCnt == LAST_BIT);
    strb.loadWord   = working && !serialMode && inValid;
    strb.emitHold   = fillTick && (src == FILL_HOLD || src == FILL_HOLDB);
    strb.emitInc    = fillTick && (src == FILL_INC);
    strb.emitSeq    = fillTick && (src == FILL_SEQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN || reconfigMode) begin
      bitCnt <= '0;
    end else if (strb.shiftEn) begin
      bitCnt <= strb.loadSerial ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !reconfigMode) begin
      seqIdx <= '0;
    end else if (strb.emitSeq) begin
      seqIdx <= (seqIdx == LAST_IDX) ? '0 : seqIdx + 1'b1;
    end
  end

  // R9
  serial_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    reconfigMode |=> (bitCnt == '0));

  // R8
  seq_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqIdx <= LAST_IDX);

  // R8
  seq_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reconfigMode) |-> (seqIdx == '0));

endmodule

// File: rtl/gfs_datapath.sv
module gfs_datapath
  import gfs_pkg::*;
#(
  parameter int                      WORD_W    = 8,
  parameter logic [MAX_SEQ*WORD_W-1:0] SEQ_TABLE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inBit,
  input  logic [WORD_W-1:0] inWord,
  input  ctrlStrb_t         strb,
  input  logic [IDX_W-1:0]  seqIdx,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid
);

  localparam logic [WORD_W-1:0] TOP_VAL = '1;

  logic [WORD_W-2:0] shiftReg;
  logic [WORD_W-1:0] assembled;
  logic [WORD_W-1:0] nextWord;
  logic [WORD_W-1:0] seqTable [MAX_SEQ];
  logic              emit;

  for (genvar i = 0; i < MAX_SEQ; i++) begin : g_table
    assign seqTable[i] = SEQ_TABLE[i*WORD_W +: WORD_W];
  end

  assign assembled = {shiftReg, inBit};
  assign emit = strb.loadSerial || strb.loadWord || strb.emitHold ||
                strb.emitInc || strb.emitSeq;

  always_comb begin
    nextWord = outWord;
    if (strb.loadSerial)   nextWord = assembled;
    else if (strb.loadWord) nextWord = inWord;
    else if (strb.emitInc)  nextWord = (outWord == TOP_VAL) ? outWord : outWord + 1'b1;
    else if (strb.emitSeq)  nextWord = seqTable[seqIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= assembled[WORD_W-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outWord  <= '0;
      outValid <= 1'b0;
    end else begin
      outWord  <= nextWord;
      outValid <= emit;
    end
  end

  // R6
  hold_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitHold |=> (outValid && outWord == $past(outWord)));

  // R7
  inc_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitInc && outWord == TOP_VAL) |=> (outWord == TOP_VAL));

  // R2
  pass_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |=> (outValid && outWord == $past(inWord)));

endmodule

// File: rtl/gapfill_seq.sv
module gapfill_seq
  import gfs_pkg::*;
#(
  parameter int                        WORD_W    = 8,
  parameter int                        SEQ_LEN   = 4,
  parameter logic [MAX_SEQ*WORD_W-1:0] SEQ_TABLE = 64'h8070_6050_4030_2010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reconfigMode,
  input  logic              serialMode,
  input  logic [1:0]        fillSel,
  input  logic              inValid,
  input  logic              inBit,
  input  logic [WORD_W-1:0] inWord,
  input  logic              sampleStrobe,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid
);

  ctrlStrb_t        strb;
  logic [IDX_W-1:0] seqIdx;

  gfs_ctrl #(.WORD_W(WORD_W), .SEQ_LEN(SEQ_LEN)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reconfigMode (reconfigMode),
    .serialMode   (serialMode),
    .fillSel      (fillSel),
    .inValid      (inValid),
    .sampleStrobe (sampleStrobe),
    .strb         (strb),
    .seqIdx       (seqIdx)
  );

  gfs_datapath #(.WORD_W(WORD_W), .SEQ_TABLE(SEQ_TABLE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inBit    (inBit),
    .inWord   (inWord),
    .strb     (strb),
    .seqIdx   (seqIdx),
    .outWord  (outWord),
    .outValid (outValid)
  );

  // R5
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reconfigMode && !sampleStrobe) |=> (!outValid && $stable(outWord)));

  // R4
  work_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reconfigMode && !inValid) |=> !outValid);

endmodule

// File: tb/gapfill_seq_test.sv
module gapfill_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reconfigMode = 1'b0;
  logic         serialMode = 1'b0;
  logic [1:0]   fillSel = 2'd0;
  logic         inValid = 1'b0;
  logic         inBit = 1'b0;
  logic [W-1:0] inWord = '0;
  logic         sampleStrobe = 1'b0;
  logic [W-1:0] outWord;
  logic         outValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  gapfill_seq uut (
    .clk(clk), .rstN(rstN), .reconfigMode(reconfigMode), .serialMode(serialMode),
    .fillSel(fillSel), .inValid(inValid), .inBit(inBit), .inWord(inWord),
    .sampleStrobe(sampleStrobe), .outWord(outWord), .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic v, input logic [W-1:0] w,
                       input logic ev, input logic [W-1:0] ew);
    checks++;
    if (v !== ev || w !== ew) begin
      failures++;
      $display("FAIL %s: valid=%0b word=%02h expected valid=%0b word=%02h",
               req, v, w, ev, ew);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleInputs();
    inValid = 1'b0;
    sampleStrobe = 1'b0;
  endtask

  task automatic sendWord(input logic [W-1:0] d, input string req);
    serialMode = 1'b0; inValid = 1'b1; inWord = d;
    tick();
    check(req, outValid, outWord, 1'b1, d);
    idleInputs();
    tick();
    check(req, outValid, outWord, 1'b0, d);
  endtask

  task automatic sendSerial(input logic [W-1:0] d, input string req);
    serialMode = 1'b1;
    for (int i = W-1; i >= 0; i--) begin
      inValid = 1'b1; inBit = d[i];
      tick();
      check(req, outValid, (i == 0) ? outWord : d, (i == 0), d);
    end
    idleInputs();
  endtask

  task automatic strobe(input logic [1:0] sel, input logic [W-1:0] exp, input string req);
    fillSel = sel; sampleStrobe = 1'b1;
    tick();
    check(req, outValid, outWord, 1'b1, exp);
    sampleStrobe = 1'b0;
    tick();
    check(req, outValid, outWord, 1'b0, exp);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    tick(); tick();
    check("R1", outValid, outWord, 1'b0, 8'h00);
    rstN = 1'b1;
  endtask

  task automatic testParallel();
    sendWord(8'hA5, "R2");
    sendWord(8'h3B, "R2");
  endtask

  task automatic testStrobeWorking();
    sampleStrobe = 1'b1; fillSel = 2'd1;
    tick();
    check("R4", outValid, outWord, 1'b0, 8'h3B);
    tick();
    check("R4", outValid, outWord, 1'b0, 8'h3B);
    sampleStrobe = 1'b0;
  endtask

  task automatic testSerial();
    sendSerial(8'h3C, "R3");
    sendSerial(8'hC5, "R3");
  endtask

  task automatic testSerialRestart();
    serialMode = 1'b1;
    for (int i = 0; i < 3; i++) begin
      inValid = 1'b1; inBit = 1'b1;
      tick();
      check("R9", outValid, outWord, 1'b0, 8'hC5);
    end
    reconfigMode = 1'b1; inValid = 1'b1; inBit = 1'b0;
    tick();
    check("R5", outValid, outWord, 1'b0, 8'hC5);
    tick();
    check("R5", outValid, outWord, 1'b0, 8'hC5);
    reconfigMode = 1'b0; idleInputs();
    tick();
    sendSerial(8'h96, "R9");
  endtask

  task automatic testHold();
    reconfigMode = 1'b1;
    strobe(2'd0, 8'h96, "R6");
    strobe(2'd3, 8'h96, "R6");
    serialMode = 1'b0; inValid = 1'b1; inWord = 8'h11;
    tick();
    check("R5", outValid, outWord, 1'b0, 8'h96);
    inValid = 1'b0;
    reconfigMode = 1'b0;
    tick();
  endtask

  task automatic testIncrement();
    sendWord(8'h41, "R2");
    reconfigMode = 1'b1;
    strobe(2'd1, 8'h42, "R7");
    reconfigMode = 1'b0;
    tick();
    sendWord(8'hFD, "R2");
    reconfigMode = 1'b1;
    strobe(2'd1, 8'hFE, "R7");
    strobe(2'd1, 8'hFF, "R7");
    strobe(2'd1, 8'hFF, "R7");
    reconfigMode = 1'b0;
    tick();
  endtask

  task automatic testSequence();
    reconfigMode = 1'b1;
    strobe(2'd2, 8'h10, "R8");
    strobe(2'd2, 8'h20, "R8");
    strobe(2'd2, 8'h30, "R8");
    strobe(2'd2, 8'h40, "R8");
    strobe(2'd2, 8'h10, "R8");
    strobe(2'd2, 8'h20, "R8");
    reconfigMode = 1'b0;
    tick();
    reconfigMode = 1'b1;
    strobe(2'd2, 8'h10, "R8");
    strobe(2'd1, 8'h11, "R10");
    strobe(2'd0, 8'h11, "R10");
    reconfigMode = 1'b0;
    tick();
    sendWord(8'h77, "R10");
  endtask

  initial begin
    testReset();
    testParallel();
    testStrobeWorking();
    testSerial();
    testSerialRestart();
    testHold();
    testIncrement();
    testSequence();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: valid=%0b word=%02h expected valid=x word=xx",
                 outValid, outWord);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule